// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is a memory-mapped controller for a bank of 32 general-purpose I/O lines. Software sets each line's direction and whether an output line works as open drain, then writes the output values. Reading the data register returns, for each line, the synchronized pad level if the line is an input, or the stored output value if it is an output. Pins reach the pad ring as three separate vectors: input, output value and output enable. All three are indexed by line number.

Every line has an edge detector behind a two-flop synchronizer. A detected edge sets that line's pending flag. The line's edge-select bit decides which edges count: either edge, or falling edges only. Software clears pending flags by writing ones to them. A mask register chooses which pending flags may raise the single combined interrupt request. The register bus completes each access in one cycle. Read data is combinational from the address while the read strobe is high, and a write takes effect at the clock edge where the write strobe is sampled.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads zero. All lines are inputs, `pin_oe` is all zero and `irq_out` is low.
- R2: Line n maps to bit 31-n of every register, so line 0 is bit 31. A direction bit of 1 makes the line an output, which drives `pin_oe[n]` high. A direction bit of 0 leaves `pin_oe[n]` low.
- R3: An output line with its open-drain bit at 0 drives `pin_out[n]` equal to its data-latch bit.
- R4: An output line with its open-drain bit at 1 behaves as follows. With data 0 it drives low (`pin_oe[n]`=1, `pin_out[n]`=0). With data 1 it releases the pin (`pin_oe[n]`=0).
- R5: The data register (offset 0x08) reads as follows. For an input line it returns the pad level, which becomes visible after the second clock edge following a pad change. For an output line it returns the data-latch bit, whatever the pad level.
- R6: With edge-select 0, both a rising and a falling synchronized edge set the pending flag (offset 0x0C). The flag becomes visible after the third clock edge following the pad change, and not before. Detection works whatever the direction and mask.
- R7: With edge-select 1 (offset 0x14), only a falling edge sets the pending flag, and a rising edge leaves it clear.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. Writing all ones clears every flag.
- R9: `irq_out` is high exactly while at least one line has both its pending flag and its mask bit (offset 0x10) set. A mask bit of 1 enables the line.
- R10: If an edge event and a write-one-to-clear hit the same pending bit in the same cycle, the flag stays set. Other bits cleared by that write still clear.
- R11: The direction (0x00), open-drain (0x04), mask and edge-select registers read back the value written. Addresses outside the six registers read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; gates `bus_rdata` |
| bus_wdata | input | 32 | Write data, register bit order |
| bus_rdata | output | 32 | Read data, zero when `bus_rd` is low |
| pin_in | input | 32 | Pad input levels, indexed by line |
| pin_out | output | 32 | Pad output values, indexed by line |
| pin_oe | output | 32 | Pad output enables, indexed by line |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Faults in the synchronizer show up at the ports as wrong timing. If a synchronizer stage is lost or the previous-sample flop is corrupted, the data register shows a pad change a cycle early, or the pending flag appears at the wrong edge. The bench reads at the exact edge counts from R5 and R6 to expose this. A pending flag that is wrongly set or cleared shows up on the very next register read and on `irq_out` in the same cycle, since the request has no register stage. A bad direction, open-drain or latch bit shows up at once on `pin_oe` and `pin_out`.

// File: rtl/gpio_port_pkg.sv
// Package: register offsets and the register-select type shared by the
// GPIO port. Assumes a byte-addressed bus with word-aligned registers.
package gpio_port_pkg;

    localparam int unsigned OFF_DIR  = 'h00;
    localparam int unsigned OFF_OD   = 'h04;
    localparam int unsigned OFF_DATA = 'h08;
    localparam int unsigned OFF_PEND = 'h0C;
    localparam int unsigned OFF_MASK = 'h10;
    localparam int unsigned OFF_EDGE = 'h14;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_OD,
        SEL_DATA,
        SEL_PEND,
        SEL_MASK,
        SEL_EDGE,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Brings each asynchronous pad input into the clock domain through two
// flops. A third flop holds the previous sample, so rising and falling
// edges can be flagged for one cycle. Assumes pads may change at any time.
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_async,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    for (genvar i = 0; i < W; i++) begin : g_line
        logic meta_q;
        logic stable_q;
        logic prev_q;

        // Purpose: two-stage synchronizer followed by the previous-sample flop.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
                prev_q   <= 1'b0;
            end else begin
                meta_q   <= pad_async[i];
                stable_q <= meta_q;
                prev_q   <= stable_q;
            end
        end

        assign level[i] = stable_q;
        assign rise[i]  = stable_q & ~prev_q;
        assign fall[i]  = ~stable_q & prev_q;
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: gpio_irq_ctrl
// Holds the pending, mask and edge-select registers, and forms the
// combined interrupt request. Pending bits are write-one-to-clear, and a
// new edge event beats a clear of the same bit. Works in register-bit order.
module gpio_irq_ctrl #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_pend,
    input  logic         wr_mask,
    input  logic         wr_edge,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    input  logic [W-1:0] level,
    output logic [W-1:0] pending,
    output logic [W-1:0] mask,
    output logic [W-1:0] edge_sel,
    output logic         irq
);

    logic [W-1:0] evt;
    logic [W-1:0] clr;

    // Purpose: qualify the detected edges with each line's edge mode.
    always_comb begin
        evt = fall | (rise & ~edge_sel);
        clr = wr_pend ? wdata : '0;
    end

    // Purpose: the mask and edge-select configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask     <= '0;
            edge_sel <= '0;
        end else begin
            if (wr_mask) mask     <= wdata;
            if (wr_edge) edge_sel <= wdata;
        end
    end

    // Purpose: pending flags; a set from an event takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= (pending & ~clr) | evt;
    end

    assign irq = |(pending & mask);

    // R8: a written one clears the bit unless an event hit it too
    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pending & $past(wdata & ~evt)) == '0));

    // R10: any event leaves its flag set on the next cycle
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & $past(evt)) == $past(evt)));

    // R6: a flag never rises without an event behind it
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pending & ~$past(pending) & ~$past(evt)) == '0));

    // R7: in falling-only mode an event only occurs with the line now low
    a_r7_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & edge_sel & level) == '0));

    // R9: the request needs at least one enabled line
    a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));

endmodule

// File: rtl/gpio_pin_regs.sv
// Module: gpio_pin_regs
// Holds the direction, open-drain and output data-latch registers, builds
// the pad drive, and forms the data-register read view: the synchronized
// level for input lines and the latch for output lines. Works in
// register-bit order.
module gpio_pin_regs #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_od,
    input  logic         wr_data,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] level,
    output logic [W-1:0] dir,
    output logic [W-1:0] od,
    output logic [W-1:0] latch,
    output logic [W-1:0] data_view,
    output logic [W-1:0] drv_out,
    output logic [W-1:0] drv_oe
);

    // Purpose: the configuration and output-latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir   <= '0;
            od    <= '0;
            latch <= '0;
        end else begin
            if (wr_dir)  dir   <= wdata;
            if (wr_od)   od    <= wdata;
            if (wr_data) latch <= wdata;
        end
    end

    // Purpose: pad drive (open-drain releases on a one) and readback view.
    always_comb begin
        drv_oe    = dir & ~(od & latch);
        drv_out   = latch & ~od;
        data_view = (level & ~dir) | (latch & dir);
    end

    // R2: only output lines may enable their pad driver
    a_r2_oe_only_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_oe & ~dir) == '0));

    // R4: an open-drain line never actively drives high
    a_r4_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((drv_oe & od & drv_out) == '0));

endmodule

// File: rtl/gpio_edge_port.sv
// Module: gpio_edge_port
// Top of the GPIO port. Decodes the single-cycle register bus, maps pad
// vectors (indexed by line) onto register bit order (line n at bit
// NUM_LINES-1-n), and drives the combined interrupt request. Assumes reads
// and writes never overlap in one cycle.
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] pin_in,
    output logic [NUM_LINES-1:0] pin_out,
    output logic [NUM_LINES-1:0] pin_oe,
    output logic                 irq_out
);

    localparam int unsigned W = NUM_LINES;

    reg_sel_e     sel;
    logic [W-1:0] in_rb, out_rb, oe_rb;
    logic [W-1:0] level, rise, fall;
    logic [W-1:0] dir, od, latch, data_view;
    logic [W-1:0] pending, mask, edge_sel;

    // Purpose: map the byte address onto a register select.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_DIR):  sel = SEL_DIR;
            ADDR_W'(OFF_OD):   sel = SEL_OD;
            ADDR_W'(OFF_DATA): sel = SEL_DATA;
            ADDR_W'(OFF_PEND): sel = SEL_PEND;
            ADDR_W'(OFF_MASK): sel = SEL_MASK;
            ADDR_W'(OFF_EDGE): sel = SEL_EDGE;
            default:           sel = SEL_NONE;
        endcase
    end

    // Line n sits at register bit W-1-n.
    for (genvar n = 0; n < W; n++) begin : g_map
        assign in_rb[W-1-n] = pin_in[n];
        assign pin_out[n]   = out_rb[W-1-n];
        assign pin_oe[n]    = oe_rb[W-1-n];
    end

    gpio_in_sync #(.W(W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_async (in_rb),
        .level     (level),
        .rise      (rise),
        .fall      (fall)
    );

    gpio_pin_regs #(.W(W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dir    (bus_wr && sel == SEL_DIR),
        .wr_od     (bus_wr && sel == SEL_OD),
        .wr_data   (bus_wr && sel == SEL_DATA),
        .wdata     (bus_wdata),
        .level     (level),
        .dir       (dir),
        .od        (od),
        .latch     (latch),
        .data_view (data_view),
        .drv_out   (out_rb),
        .drv_oe    (oe_rb)
    );

    gpio_irq_ctrl #(.W(W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pend  (bus_wr && sel == SEL_PEND),
        .wr_mask  (bus_wr && sel == SEL_MASK),
        .wr_edge  (bus_wr && sel == SEL_EDGE),
        .wdata    (bus_wdata),
        .rise     (rise),
        .fall     (fall),
        .level    (level),
        .pending  (pending),
        .mask     (mask),
        .edge_sel (edge_sel),
        .irq      (irq_out)
    );

    // Purpose: combinational read mux, gated by the read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_DIR:  bus_rdata = dir;
                SEL_OD:   bus_rdata = od;
                SEL_DATA: bus_rdata = data_view;
                SEL_PEND: bus_rdata = pending;
                SEL_MASK: bus_rdata = mask;
                SEL_EDGE: bus_rdata = edge_sel;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R1: nothing is driven or requested in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && !irq_out));

endmodule

// File: tb/gpio_edge_port_tb.sv
// Scoreboard bench: driver tasks push expected items, and a monitor pops
// each one and compares it with the port it names.
module gpio_edge_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    string       q_tag[$];
    logic [31:0] q_exp[$];
    int          q_kind[$];
    event        sample_ev;

    localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_IRQ = 3;

    always #10 clk = ~clk;

    gpio_edge_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] lb(input int n);
        return 32'h1 << (31 - n);
    endfunction

    function automatic logic [31:0] ln(input int n);
        return 32'h1 << n;
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic expect_val(input int kind, input logic [4:0] a,
                              input logic [31:0] e, input string tag);
        @(negedge clk);
        if (kind == K_RD) begin
            bus_addr = a;
            bus_rd   = 1'b1;
        end
        q_kind.push_back(kind);
        q_exp.push_back(e);
        q_tag.push_back(tag);
        #2 -> sample_ev;
        #1 bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: pop each expected item and compare with the named output.
    initial begin
        forever begin
            @(sample_ev);
            while (q_kind.size() > 0) begin
                int          k;
                logic [31:0] e, act;
                string       t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                case (k)
                    K_RD:    act = bus_rdata;
                    K_OE:    act = pin_oe;
                    K_OUT:   act = pin_out & pin_oe;
                    default: act = {31'b0, irq_out};
                endcase
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R11 unmapped address
        expect_val(K_RD, 5'h00, 32'h0, "R1 dir reset");
        expect_val(K_RD, 5'h04, 32'h0, "R1 od reset");
        expect_val(K_RD, 5'h08, 32'h0, "R1 data reset");
        expect_val(K_RD, 5'h0C, 32'h0, "R1 pending reset");
        expect_val(K_RD, 5'h10, 32'h0, "R1 mask reset");
        expect_val(K_RD, 5'h14, 32'h0, "R1 edge reset");
        expect_val(K_OE, 5'h00, 32'h0, "R1 pin_oe reset");
        expect_val(K_IRQ, 5'h00, 32'h0, "R1 irq reset");
        expect_val(K_RD, 5'h18, 32'h0, "R11 unmapped reads zero");

        // R2, R3 push-pull outputs on lines 0 and 5
        wr(5'h00, lb(0) | lb(5));
        wr(5'h08, lb(0));
        expect_val(K_RD, 5'h00, lb(0) | lb(5), "R11 dir readback");
        expect_val(K_OE, 5'h00, ln(0) | ln(5), "R2 bit-reversed direction");
        expect_val(K_OUT, 5'h00, ln(0), "R3 push-pull drive");

        // R4 open drain
        wr(5'h04, lb(0) | lb(5));
        expect_val(K_OE, 5'h00, ln(5), "R4 od release on one");
        expect_val(K_OUT, 5'h00, 32'h0, "R4 od drives low");
        expect_val(K_RD, 5'h04, lb(0) | lb(5), "R11 od readback");
        wr(5'h04, 32'h0);

        // R5 readback and R6 timing: lines 10 (input) and 5 (output) rise
        set_pins(ln(10) | ln(5));
        @(posedge clk);
        @(posedge clk);
        expect_val(K_RD, 5'h08, lb(0) | lb(10), "R5 data view");
        expect_val(K_RD, 5'h0C, lb(10) | lb(5), "R6 rise pending at third edge");

        // R8 write-one-to-clear
        wr(5'h0C, 32'h0);
        expect_val(K_RD, 5'h0C, lb(10) | lb(5), "R8 zero write no effect");
        wr(5'h0C, lb(5));
        expect_val(K_RD, 5'h0C, lb(10), "R8 single clear");
        wr(5'h0C, 32'hFFFF_FFFF);
        expect_val(K_RD, 5'h0C, 32'h0, "R8 clear all");

        // R6 falling edge in both-edge mode
        set_pins(ln(5));
        settle();
        expect_val(K_RD, 5'h0C, lb(10), "R6 fall pending");
        wr(5'h0C, 32'hFFFF_FFFF);

        // R7 falling-only mode on line 12
        wr(5'h14, lb(12));
        expect_val(K_RD, 5'h14, lb(12), "R11 edge readback");
        set_pins(ln(5) | ln(12));
        settle();
        expect_val(K_RD, 5'h0C, 32'h0, "R7 rise ignored");
        set_pins(ln(5));
        settle();
        expect_val(K_RD, 5'h0C, lb(12), "R7 fall pending");

        // R9 mask and request
        expect_val(K_IRQ, 5'h00, 32'h0, "R9 masked no irq");
        wr(5'h10, lb(3));
        expect_val(K_IRQ, 5'h00, 32'h0, "R9 other line enabled");
        wr(5'h10, lb(3) | lb(12));
        expect_val(K_IRQ, 5'h00, 32'h1, "R9 enabled irq");
        expect_val(K_RD, 5'h10, lb(3) | lb(12), "R11 mask readback");
        wr(5'h0C, lb(12));
        expect_val(K_IRQ, 5'h00, 32'h0, "R9 irq drops on clear");

        // R10 event beats clear on line 20, line 21 clears normally
        set_pins(ln(5) | ln(20) | ln(21));
        settle();
        expect_val(K_RD, 5'h0C, lb(20) | lb(21), "R10 setup");
        set_pins(ln(5) | ln(21));
        @(posedge clk);
        @(posedge clk);
        wr(5'h0C, lb(20) | lb(21));
        expect_val(K_RD, 5'h0C, lb(20), "R10 event wins");
        wr(5'h0C, 32'hFFFF_FFFF);
        expect_val(K_RD, 5'h0C, 32'h0, "R10 final clear");

        repeat (2) @(negedge clk);
        if (q_kind.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: actual %0d left expected 0", q_kind.size());
        end
        done = 1'b1;
        summary();
    end

endmodule